// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Controller

This block guards a processor against runaway software. A free-running counter counts system clocks from zero. When it has counted a programmable number of clocks without being restarted, the block sets a time-out flag and, when the external interrupt enable is high, raises an interrupt. That is the first stage.

The second stage is a fixed 512-clock grace window that starts at the time-out. If software restarts the timer during the window, nothing more happens. If the window runs out and the reset enable is set, the block issues a one-cycle system reset request and sets a sticky reset-cause flag. That flag survives the watchdog reset, so software can read it after the restart. Only a software write of 0 or a power-fail reset clears it.

Software uses a single 4-bit control/status register. Writes are synchronous on a strobe and reads are combinational. Bit 3 is the time-out flag, bit 2 the reset-cause flag, bit 1 the reset enable and bit 0 the restart command.

Top module: `wdog_ctrl`

## Requirements
- R1: While `por_n` is low, `reg_rdata` reads 0, and `irq` and `wd_rst_req` are 0. Bit 1 (reset enable) comes out of reset as 0.
- R2: A write with bit 0 = 1 zeroes the counter and cancels any grace window. The next time-out then occurs exactly TIMEOUT_CLKS clocks after the write edge. Bit 0 always reads 0.
- R3: Bit 3, the time-out flag, is set TIMEOUT_CLKS clocks after the counter last started from zero.
- R4: `irq` equals bit 3 AND `irq_en`. When `irq_en` is low, bit 3 is still set at time-out.
- R5: If reset is enabled and no restart occurs, `wd_rst_req` goes high for exactly one cycle. It rises exactly GRACE_CLKS (512) clocks after bit 3 was set.
- R6: With bit 1 = 0, the grace window ends without a reset request, and bit 2 stays 0.
- R7: Bit 2, the reset-cause flag, is set in the same edge as the reset request. It persists through later cycles. A write of 0 to bit 2 clears it, and a write of 1 to bit 2 has no effect.
- R8: A write of 0 to bit 3 clears the time-out flag, and a write of 1 to bit 3 has no effect. If a clearing write falls in the same cycle as a time-out, the flag ends up set.
- R9: A restart written in the same cycle as grace-window expiry cancels the reset request, and bit 2 is not set.
- R10: A power-fail reset (`por_n` low) clears bit 2 and bit 1 asynchronously.
- R11: After a reset request, the counter restarts from zero. The next time-out then occurs TIMEOUT_CLKS clocks after the request edge.
- R12: Bit 1 takes the written value on every register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-fail reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Write data: {tflag, rflag, rst_en, restart} |
| reg_rdata | output | 4 | Read data, same layout, bit 0 reads 0 |
| irq_en | input | 1 | Watchdog interrupt enable |
| irq | output | 1 | Interrupt request |
| wd_rst_req | output | 1 | One-cycle system reset request |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the grace-window expiry and a software restart. The second is a time-out and a software write that clears the time-out flag. The bench counts clocks from a restart and puts the write strobe exactly on the expiry edge, or exactly on the time-out edge. It then checks that no reset pulse appears and the cause flag stays clear in the first case, and that the time-out flag ends up set in the second. A behavioural reference model, updated on every edge, also compares all outputs on each cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned REG_W       = 4;
   localparam int unsigned BIT_RESTART = 0;
   localparam int unsigned BIT_RSTEN   = 1;
   localparam int unsigned BIT_RFLAG   = 2;
   localparam int unsigned BIT_TFLAG   = 3;

   typedef enum logic {
      PH_RUN   = 1'b0,
      PH_GRACE = 1'b1
   } wdog_phase_e;
endpackage

// File: rtl/wdog_tick_cnt.sv
module wdog_tick_cnt #(
   parameter int unsigned LIMIT = 1024
) (
   input  logic clk,
   input  logic por_n,
   input  logic clr,
   input  logic en,
   output logic last
);
   localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [W-1:0] LAST_VAL = W'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("wdog_tick_cnt: LIMIT must be at least 2");
   end

   logic [W-1:0] val;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      val <= '0;
      else if (clr)    val <= '0;
      else if (en)     val <= val + 1'b1;
   end

   assign last = en && (val == LAST_VAL);

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      clr |=> (val == '0)); // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!por_n)
      (val <= LAST_VAL)); // R3
endmodule

// File: rtl/wdog_csr.sv
module wdog_csr
   import wdog_pkg::*;
(
   input  logic             clk,
   input  logic             por_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             tmo_evt,
   input  logic             rst_evt,
   output logic             restart,
   output logic             rst_en,
   output logic             tmo_flag,
   output logic             rst_flag,
   output logic [REG_W-1:0] rdata
);
   logic clr_tflag, clr_rflag;

   assign restart   = wr && wdata[BIT_RESTART];
   assign clr_tflag = wr && !wdata[BIT_TFLAG];
   assign clr_rflag = wr && !wdata[BIT_RFLAG];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         tmo_flag <= 1'b0;
      else if (tmo_evt)   tmo_flag <= 1'b1;
      else if (clr_tflag) tmo_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         rst_flag <= 1'b0;
      else if (rst_evt)   rst_flag <= 1'b1;
      else if (clr_rflag) rst_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)   rst_en <= 1'b0;
      else if (wr)  rst_en <= wdata[BIT_RSTEN];
   end

   always_comb begin
      rdata              = '0;
      rdata[BIT_TFLAG]   = tmo_flag;
      rdata[BIT_RFLAG]   = rst_flag;
      rdata[BIT_RSTEN]   = rst_en;
      rdata[BIT_RESTART] = 1'b0;
   end

   AST_TFLAG_SET: assert property (@(posedge clk) disable iff (!por_n)
      tmo_evt |=> tmo_flag); // R3
   AST_RFLAG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_evt && !clr_rflag) |=> $stable(rst_flag)); // R7
   AST_TFLAG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (!tmo_evt && !clr_tflag) |=> $stable(tmo_flag)); // R8
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
   import wdog_pkg::*;
#(
   parameter int unsigned TIMEOUT_CLKS = 1024,
   parameter int unsigned GRACE_CLKS   = 512,
   parameter bit          IRQ_REG      = 1'b0
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       reg_wr,
   input  logic [3:0] reg_wdata,
   output logic [3:0] reg_rdata,
   input  logic       irq_en,
   output logic       irq,
   output logic       wd_rst_req
);
   if (TIMEOUT_CLKS < 2) begin : g_bad_tmo
      $error("wdog_ctrl: TIMEOUT_CLKS must be at least 2");
   end
   if (GRACE_CLKS < 2) begin : g_bad_grace
      $error("wdog_ctrl: GRACE_CLKS must be at least 2");
   end

   wdog_phase_e phase;
   logic restart, rst_en, tmo_flag, rst_flag;
   logic main_last, grace_last;
   logic tmo_evt, grace_end, rst_evt;

   wdog_csr i_csr (
      .clk      (clk),
      .por_n    (por_n),
      .wr       (reg_wr),
      .wdata    (reg_wdata),
      .tmo_evt  (tmo_evt),
      .rst_evt  (rst_evt),
      .restart  (restart),
      .rst_en   (rst_en),
      .tmo_flag (tmo_flag),
      .rst_flag (rst_flag),
      .rdata    (reg_rdata)
   );

   wdog_tick_cnt #(.LIMIT(TIMEOUT_CLKS)) i_main_cnt (
      .clk   (clk),
      .por_n (por_n),
      .clr   (restart || main_last),
      .en    (phase == PH_RUN),
      .last  (main_last)
   );

   wdog_tick_cnt #(.LIMIT(GRACE_CLKS)) i_grace_cnt (
      .clk   (clk),
      .por_n (por_n),
      .clr   (restart || grace_last),
      .en    (phase == PH_GRACE),
      .last  (grace_last)
   );

   assign tmo_evt   = main_last  && !restart;
   assign grace_end = grace_last && !restart;
   assign rst_evt   = grace_end  && rst_en;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          phase <= PH_RUN;
      else if (restart)    phase <= PH_RUN;
      else if (tmo_evt)    phase <= PH_GRACE;
      else if (grace_end)  phase <= PH_RUN;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) wd_rst_req <= 1'b0;
      else        wd_rst_req <= rst_evt;
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) irq <= 1'b0;
         else        irq <= tmo_flag && irq_en;
      end
   end else begin : g_irq_comb
      assign irq = tmo_flag && irq_en;
      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!por_n)
         irq |-> (tmo_flag && irq_en)); // R4
   end

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!por_n)
      wd_rst_req |=> !wd_rst_req); // R5
   AST_REQ_FROM_GRACE: assert property (@(posedge clk) disable iff (!por_n)
      wd_rst_req |-> ($past(phase) == PH_GRACE)); // R5
   AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
      wd_rst_req |-> $past(rst_en)); // R6
   AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
      wd_rst_req |-> rst_flag); // R7
   AST_RESTART_NO_REQ: assert property (@(posedge clk) disable iff (!por_n)
      restart |=> !wd_rst_req); // R9
   AST_REQ_BACK_TO_RUN: assert property (@(posedge clk) disable iff (!por_n)
      wd_rst_req |-> (phase == PH_RUN)); // R11
endmodule

// File: tb/test_wdog_ctrl.sv
`timescale 1ns/1ps
module test_wdog_ctrl;
   localparam int TO = 40;
   localparam int GR = 512;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [3:0] reg_wdata = '0;
   logic [3:0] reg_rdata;
   logic irq_en = 1'b0;
   logic irq, wd_rst_req;

   int total = 0;
   int bad = 0;
   int pulses = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   wdog_ctrl #(.TIMEOUT_CLKS(TO), .GRACE_CLKS(GR)) i_wdog_ctrl (
      .clk(clk), .por_n(por_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_en(irq_en), .irq(irq), .wd_rst_req(wd_rst_req)
   );

   // behavioural reference model
   int m_cnt, m_g;
   bit m_grace, m_tf, m_rf, m_en, m_req;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_cnt = 0; m_g = 0; m_grace = 0; m_tf = 0; m_rf = 0; m_en = 0; m_req = 0;
      end else begin
         bit rs, tmo, expd, rev;
         rs = reg_wr && reg_wdata[0];
         tmo = 0; expd = 0;
         if (rs) begin
            m_cnt = 0; m_g = 0; m_grace = 0;
         end else if (!m_grace) begin
            if (m_cnt == TO - 1) begin tmo = 1; m_grace = 1; m_g = 0; m_cnt = 0; end
            else m_cnt++;
         end else begin
            if (m_g == GR - 1) begin expd = 1; m_grace = 0; m_g = 0; end
            else m_g++;
         end
         rev = expd && m_en;
         m_req = rev;
         if (tmo) m_tf = 1; else if (reg_wr && !reg_wdata[3]) m_tf = 0;
         if (rev) m_rf = 1; else if (reg_wr && !reg_wdata[2]) m_rf = 0;
         if (reg_wr) m_en = reg_wdata[1];
      end
   end

   task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (wd_rst_req === 1'b1) pulses++;
      if (por_n && !finished) begin
         check("R3 tflag model", {3'b0, reg_rdata[3]}, {3'b0, m_tf});
         check("R7 rflag model", {3'b0, reg_rdata[2]}, {3'b0, m_rf});
         check("R12 rst_en model", {3'b0, reg_rdata[1]}, {3'b0, m_en});
         check("R2 restart bit reads 0", {3'b0, reg_rdata[0]}, 4'h0);
         check("R4 irq model", {3'b0, irq}, {3'b0, m_tf && irq_en});
         check("R5 req model", {3'b0, wd_rst_req}, {3'b0, m_req});
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(logic [3:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      int p0;
      step(3);
      check("R1 rdata in reset", reg_rdata, 4'h0);
      check("R1 irq/req in reset", {2'b0, irq, wd_rst_req}, 4'h0);
      por_n = 1'b1;

      // R2/R3: time-out exactly TO clocks after restart edge
      wr_reg(4'b0001);
      step(TO - 1);
      check("R3 flag not yet", {3'b0, reg_rdata[3]}, 4'h0);
      step(1);
      check("R3 flag at time-out", {3'b0, reg_rdata[3]}, 4'h1);
      check("R4 irq low with enable low", {3'b0, irq}, 4'h0);
      irq_en = 1'b1; #1;
      check("R4 irq follows enable", {3'b0, irq}, 4'h1);

      // R6: disabled reset, grace window ends quietly
      step(GR + 2);
      check("R6 no reset pulse", pulses[3:0], 4'h0);
      check("R6 rflag stays 0", {3'b0, reg_rdata[2]}, 4'h0);

      // R8: write 1 to bit3 ignored, write 0 clears
      wr_reg(4'b1000);
      check("R8 write 1 ignored", {3'b0, reg_rdata[3]}, 4'h1);
      wr_reg(4'b0000);
      check("R8 write 0 clears", {3'b0, reg_rdata[3]}, 4'h0);

      // R5/R7/R11: full escalation
      wr_reg(4'b0011);
      check("R12 enable written", {3'b0, reg_rdata[1]}, 4'h1);
      step(TO);
      check("R3 flag set", {3'b0, reg_rdata[3]}, 4'h1);
      p0 = pulses;
      step(GR - 1);
      check("R5 no early req", {3'b0, wd_rst_req}, 4'h0);
      step(1);
      check("R5 req after grace", {3'b0, wd_rst_req}, 4'h1);
      check("R7 rflag with req", {3'b0, reg_rdata[2]}, 4'h1);
      step(1);
      check("R5 req one cycle", {3'b0, wd_rst_req}, 4'h0);
      check("R5 single pulse", 4'(pulses - p0), 4'h1);
      wr_reg(4'b0110);
      check("R11 flag cleared", {3'b0, reg_rdata[3]}, 4'h0);
      step(TO - 3);
      check("R11 no early time-out", {3'b0, reg_rdata[3]}, 4'h0);
      step(1);
      check("R11 time-out after req", {3'b0, reg_rdata[3]}, 4'h1);
      check("R7 rflag persists", {3'b0, reg_rdata[2]}, 4'h1);
      wr_reg(4'b0110);
      check("R7 write 1 ignored", {3'b0, reg_rdata[2]}, 4'h1);
      wr_reg(4'b0010);
      check("R7 write 0 clears", {3'b0, reg_rdata[2]}, 4'h0);

      // R9: restart on the expiry edge
      wr_reg(4'b0011);
      p0 = pulses;
      step(TO + GR - 1);
      wr_reg(4'b0011);
      step(2);
      check("R9 restart cancels req", 4'(pulses - p0), 4'h0);
      check("R9 rflag not set", {3'b0, reg_rdata[2]}, 4'h0);

      // R8: clear and time-out on the same edge
      wr_reg(4'b0011);
      step(TO - 1);
      wr_reg(4'b0010);
      check("R8 set wins over clear", {3'b0, reg_rdata[3]}, 4'h1);

      // R10: power-fail clears the sticky flag
      wr_reg(4'b0011);
      step(TO + GR + 1);
      check("R7 rflag before power-fail", {3'b0, reg_rdata[2]}, 4'h1);
      por_n = 1'b0; #1;
      check("R10 power-fail clears", reg_rdata, 4'h0);
      check("R1 outputs in reset", {2'b0, irq, wd_rst_req}, 4'h0);
      step(1);
      por_n = 1'b1;
      step(2);
      finish_run();
   end
endmodule